// File: doc/BRIEF.md
# Parallel Disk Port Cycle Sequencer

This block runs one host-side register or data cycle on a parallel disk port. A request names a read or a write, an 8-bit or 16-bit width, an address, the write data and a timing mode. The block then drives the device address, holds it for a setup interval, pulses the active-low read or write strobe, and keeps the address and write data for a hold interval. It then pads the cycle out to the minimum cycle length of the selected mode.

All intervals are counts of the system clock. They are derived from nanosecond limits by ceiling division with the `CLK_NS` parameter. Each phase counter loads its count from the row of the mode latched with the request. The device can stretch the strobe by pulling its ready line low early in the strobe. If ready stays low too long, the strobe is ended and the cycle completes with an error flag. Read data is captured on the clock edge that negates the read strobe. It is returned together with a one-cycle done pulse.

Top module: `pio_cycle_seq`

## Requirements
- R1: A mode code selects the timing row: 0 slowest, 1 middle, 2 fastest, and code 3 uses the row of code 0. The first busy cycle starts the address setup phase, which lasts ceil(70/50/30 ns / CLK_NS) cycles for modes 0/1/2 before the strobe asserts.
- R2: A 16-bit cycle without ready stretching holds its strobe low for ceil(165/125/100 ns / CLK_NS) cycles for modes 0/1/2.
- R3: An 8-bit cycle holds its strobe low for ceil(290 ns / CLK_NS) cycles in every mode. An 8-bit read returns bits 15:8 as zero, and an 8-bit write drives bits 15:8 of the data bus as zero.
- R4: After the strobe negates, the write data stays driven (output enable high) for max(ceil(t_dh), ceil(t_ah)) cycles. The data hold t_dh is 30/20/15 ns and the address hold t_ah is 20/15/10 ns for modes 0/1/2.
- R5: Busy stays high for max(ceil(600/383/240 ns / CLK_NS), setup + actual strobe width + hold) cycles. Done is high for exactly the one cycle right after busy falls.
- R6: Read data equals the data bus value present in the last strobe-low cycle. It is held unchanged until the next read completes.
- R7: A write asserts only the write strobe and a read only the read strobe, never both. The address and write data are stable from the first busy cycle until busy falls.
- R8: If ready is low in any of the first ceil(35 ns / CLK_NS) strobe cycles, the strobe stays low while ready is low. With ready low for the first L strobe cycles, the width is max(nominal width, L+1).
- R9: Ready going low only after that early window has no effect on the strobe width.
- R10: If ready is heeded low for ceil(1250 ns / CLK_NS) consecutive strobe cycles, the strobe ends after that many cycles and err is high together with done. One cycle less of low ready completes without err.
- R11: A request is taken only while not busy. A request during a cycle changes neither its address nor its length.
- R12: During and after reset, busy, done, err and output enable are low and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a cycle (taken when idle) |
| req_write_i | input | 1 | 1 write, 0 read |
| req_wide_i | input | 1 | 1 16-bit, 0 8-bit |
| req_mode_i | input | 2 | Timing mode code |
| req_addr_i | input | AW | Device address incl. selects |
| req_wdata_i | input | DW | Write data |
| dev_rdata_i | input | DW | Data bus in |
| dev_ready_i | input | 1 | Device ready, low to stretch |
| dev_addr_o | output | AW | Device address |
| dev_rd_n_o | output | 1 | Read strobe, active low |
| dev_wr_n_o | output | 1 | Write strobe, active low |
| dev_wdata_o | output | DW | Data bus out |
| dev_wdata_oe_o | output | 1 | Data bus output enable |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Ready timeout, with done |
| rdata_o | output | DW | Captured read data |

## Verification
The nominal width counter can run out in the very cycle that ready returns high. In that case the strobe must end there without an extra cycle. One cycle later, the width must grow by exactly one. The bench provokes this by releasing ready after PW-1 and then PW strobe cycles, and it judges the measured strobe width. The ready timeout and a ready release on the timeout cycle are also set against each other with low periods of the limit and one less, and the bench judges both the width and the err flag seen with done.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_RECOV
  } phase_e;

  localparam int unsigned NARROW_PW_NS = 290;
  localparam int unsigned RDY_WIN_NS   = 35;
  localparam int unsigned RDY_LIM_NS   = 1250;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned cycle_ns(logic [1:0] m);
    case (m)
      2'd1:    return 383;
      2'd2:    return 240;
      default: return 600;
    endcase
  endfunction

  function automatic int unsigned setup_ns(logic [1:0] m);
    case (m)
      2'd1:    return 50;
      2'd2:    return 30;
      default: return 70;
    endcase
  endfunction

  function automatic int unsigned wide_pw_ns(logic [1:0] m);
    case (m)
      2'd1:    return 125;
      2'd2:    return 100;
      default: return 165;
    endcase
  endfunction

  // larger of data hold and address hold after strobe negation
  function automatic int unsigned hold_ns(logic [1:0] m);
    case (m)
      2'd1:    return 20;
      2'd2:    return 15;
      default: return 30;
    endcase
  endfunction

endpackage

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
  import pio_seq_pkg::*;
#(
  parameter int unsigned CLK_NS = 10,
  parameter int unsigned CW     = 8
) (
  input  logic [1:0]    mode_i,
  input  logic          wide_i,
  output logic [CW-1:0] setup_o,
  output logic [CW-1:0] width_o,
  output logic [CW-1:0] hold_o,
  output logic [CW-1:0] cycle_o
);

  always_comb begin
    setup_o = CW'(ns2cyc(setup_ns(mode_i), CLK_NS));
    width_o = wide_i ? CW'(ns2cyc(wide_pw_ns(mode_i), CLK_NS))
                     : CW'(ns2cyc(NARROW_PW_NS, CLK_NS));
    hold_o  = CW'(ns2cyc(hold_ns(mode_i), CLK_NS));
    cycle_o = CW'(ns2cyc(cycle_ns(mode_i), CLK_NS));
  end

endmodule

// File: rtl/pio_ready_ctl.sv
module pio_ready_ctl #(
  parameter int unsigned WIN_CYC = 4,
  parameter int unsigned LIM_CYC = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic in_strobe_i,
  input  logic ready_i,
  output logic stretch_o,
  output logic timeout_o,
  output logic err_o
);

  localparam int unsigned EW = $clog2(WIN_CYC + 1) + 1;
  localparam int unsigned LW = $clog2(LIM_CYC + 1) + 1;

  logic [EW-1:0] elap_q, elap_d;
  logic [LW-1:0] low_q, low_d;
  logic          seen_q, seen_d;
  logic          err_q, err_d;
  logic          in_win;

  always_comb begin
    in_win    = elap_q < EW'(WIN_CYC);
    stretch_o = in_strobe_i && !ready_i && (seen_q || in_win);
    timeout_o = stretch_o && (low_q == LW'(LIM_CYC - 1));

    elap_d = '0;
    seen_d = 1'b0;
    low_d  = '0;
    if (in_strobe_i) begin
      elap_d = in_win ? elap_q + EW'(1) : elap_q;
      seen_d = seen_q || (stretch_o && in_win);
      low_d  = stretch_o ? low_q + LW'(1) : '0;
    end

    err_d = err_q;
    if (start_i)        err_d = 1'b0;
    else if (timeout_o) err_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elap_q <= '0;
      seen_q <= 1'b0;
      low_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      elap_q <= elap_d;
      seen_q <= seen_d;
      low_q  <= low_d;
      err_q  <= err_d;
    end
  end

  assign err_o = err_q;

endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
  import pio_seq_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] setup_i,
  input  logic [CW-1:0] width_i,
  input  logic [CW-1:0] hold_i,
  input  logic [CW-1:0] cycle_i,
  input  logic          stretch_i,
  input  logic          timeout_i,
  output phase_e        phase_o,
  output logic          strobe_end_o,
  output logic          done_o
);

  phase_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] tot_q, tot_d;
  logic          done_q, done_d;

  always_comb begin
    st_d         = st_q;
    cnt_d        = cnt_q;
    tot_d        = (st_q != PH_IDLE) ? tot_q + CW'(1) : tot_q;
    strobe_end_o = 1'b0;
    case (st_q)
      PH_IDLE: if (start_i) begin
        st_d  = PH_SETUP;
        cnt_d = setup_i - CW'(1);
        tot_d = CW'(1);
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          st_d  = PH_STROBE;
          cnt_d = width_i - CW'(1);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      PH_STROBE: begin
        strobe_end_o = ((cnt_q == '0) && !stretch_i) || timeout_i;
        if (strobe_end_o) begin
          st_d  = PH_HOLD;
          cnt_d = hold_i - CW'(1);
        end else if (cnt_q != '0) begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) st_d = (tot_q >= cycle_i) ? PH_IDLE : PH_RECOV;
        else             cnt_d = cnt_q - CW'(1);
      end
      PH_RECOV: if (tot_q >= cycle_i) st_d = PH_IDLE;
      default: st_d = PH_IDLE;
    endcase
    done_d = (st_d == PH_IDLE) && (st_q != PH_IDLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      tot_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      tot_q  <= tot_d;
      done_q <= done_d;
    end
  end

  assign phase_o = st_q;
  assign done_o  = done_q;

endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
  import pio_seq_pkg::*;
#(
  parameter int unsigned CLK_NS = 10,
  parameter int unsigned AW     = 5,
  parameter int unsigned DW     = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_write_i,
  input  logic          req_wide_i,
  input  logic [1:0]    req_mode_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] dev_rdata_i,
  input  logic          dev_ready_i,
  output logic [AW-1:0] dev_addr_o,
  output logic          dev_rd_n_o,
  output logic          dev_wr_n_o,
  output logic [DW-1:0] dev_wdata_o,
  output logic          dev_wdata_oe_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o
);

  localparam int unsigned HALF    = DW / 2;
  localparam int unsigned WIN_CYC = ns2cyc(RDY_WIN_NS, CLK_NS);
  localparam int unsigned LIM_CYC = ns2cyc(RDY_LIM_NS, CLK_NS);
  localparam int unsigned MAX_CYC = ns2cyc(600 + 70 + 30 + NARROW_PW_NS + RDY_LIM_NS, CLK_NS);
  localparam int unsigned CW      = $clog2(MAX_CYC + 2) + 1;

  logic [1:0] rs_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= '0;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  phase_e        phase;
  logic          idle, accept, strobe_end, stretch, timeout, err_flag, done;
  logic          write_q, wide_q;
  logic [1:0]    mode_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [CW-1:0] t_setup, t_width, t_hold, t_cycle;

  assign idle   = (phase == PH_IDLE);
  assign accept = req_i && idle;

  pio_timing_sel #(.CLK_NS(CLK_NS), .CW(CW)) u_tsel (
    .mode_i  (idle ? req_mode_i : mode_q),
    .wide_i  (idle ? req_wide_i : wide_q),
    .setup_o (t_setup),
    .width_o (t_width),
    .hold_o  (t_hold),
    .cycle_o (t_cycle)
  );

  pio_ready_ctl #(.WIN_CYC(WIN_CYC), .LIM_CYC(LIM_CYC)) u_rdy (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .start_i     (accept),
    .in_strobe_i (phase == PH_STROBE),
    .ready_i     (dev_ready_i),
    .stretch_o   (stretch),
    .timeout_o   (timeout),
    .err_o       (err_flag)
  );

  pio_phase_fsm #(.CW(CW)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .start_i      (accept),
    .setup_i      (t_setup),
    .width_i      (t_width),
    .hold_i       (t_hold),
    .cycle_i      (t_cycle),
    .stretch_i    (stretch),
    .timeout_i    (timeout),
    .phase_o      (phase),
    .strobe_end_o (strobe_end),
    .done_o       (done)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      wide_q  <= 1'b0;
      mode_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      write_q <= req_write_i;
      wide_q  <= req_wide_i;
      mode_q  <= req_mode_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wide_i ? req_wdata_i : {{HALF{1'b0}}, req_wdata_i[HALF-1:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)                       rdata_q <= '0;
    else if (strobe_end && !write_q)  rdata_q <= wide_q ? dev_rdata_i
                                                        : {{HALF{1'b0}}, dev_rdata_i[HALF-1:0]};
  end

  assign dev_addr_o     = addr_q;
  assign dev_wdata_o    = wdata_q;
  assign dev_rd_n_o     = !((phase == PH_STROBE) && !write_q);
  assign dev_wr_n_o     = !((phase == PH_STROBE) && write_q);
  assign dev_wdata_oe_o = write_q && (phase inside {PH_SETUP, PH_STROBE, PH_HOLD});
  assign busy_o         = !idle;
  assign done_o         = done;
  assign err_o          = done && err_flag;
  assign rdata_o        = rdata_q;

endmodule

// File: rtl/pio_cycle_seq_chk.sv
module pio_cycle_seq_chk #(
  parameter int unsigned AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          dev_rd_n_o,
  input logic          dev_wr_n_o,
  input logic          dev_wdata_oe_o,
  input logic [AW-1:0] dev_addr_o
);

  p_one_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rd_n_o || dev_wr_n_o);

  p_addr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(dev_addr_o));

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (dev_rd_n_o && dev_wr_n_o && !dev_wdata_oe_o));

  p_setup_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (dev_rd_n_o && dev_wr_n_o));

  p_strobe_neg_in_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dev_rd_n_o) || $rose(dev_wr_n_o)) |-> busy_o);

  p_done_after_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_with_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

endmodule

bind pio_cycle_seq pio_cycle_seq_chk #(.AW(AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .err_o          (err_o),
  .dev_rd_n_o     (dev_rd_n_o),
  .dev_wr_n_o     (dev_wr_n_o),
  .dev_wdata_oe_o (dev_wdata_oe_o),
  .dev_addr_o     (dev_addr_o)
);

// File: tb/pio_cycle_seq_test.sv
module pio_cycle_seq_test;
  localparam int CLK_NS = 10;
  localparam int AW = 5;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic          req_i, req_write_i, req_wide_i, dev_ready_i;
  logic [1:0]    req_mode_i;
  logic [AW-1:0] req_addr_i;
  logic [DW-1:0] req_wdata_i, dev_rdata_i;
  logic [AW-1:0] dev_addr_o;
  logic          dev_rd_n_o, dev_wr_n_o, dev_wdata_oe_o, busy_o, done_o, err_o;
  logic [DW-1:0] dev_wdata_o, rdata_o;

  pio_cycle_seq #(.CLK_NS(CLK_NS), .AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .req_write_i(req_write_i),
    .req_wide_i(req_wide_i), .req_mode_i(req_mode_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .dev_rdata_i(dev_rdata_i), .dev_ready_i(dev_ready_i),
    .dev_addr_o(dev_addr_o), .dev_rd_n_o(dev_rd_n_o), .dev_wr_n_o(dev_wr_n_o),
    .dev_wdata_o(dev_wdata_o), .dev_wdata_oe_o(dev_wdata_oe_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int cyc(input int ns);
    int c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic int e_t0(input int m);
    return (m == 1) ? 383 : (m == 2) ? 240 : 600;
  endfunction
  function automatic int e_t1(input int m);
    return (m == 1) ? 50 : (m == 2) ? 30 : 70;
  endfunction
  function automatic int e_pw(input int m, input bit wide);
    if (!wide) return 290;
    return (m == 1) ? 125 : (m == 2) ? 100 : 165;
  endfunction
  function automatic int e_dh(input int m);
    return (m == 1) ? 20 : (m == 2) ? 15 : 30;
  endfunction
  function automatic int e_ah(input int m);
    return (m == 1) ? 15 : (m == 2) ? 10 : 20;
  endfunction

  localparam int RDY = (1250 + CLK_NS - 1) / CLK_NS;
  localparam int WIN = (35 + CLK_NS - 1) / CLK_NS;

  // rmode: 0 ready high, 1 low for first L strobe cycles, 2 low from strobe cycle WIN on
  task automatic run(input bit wr, input bit wide, input int md, input int rmode,
                     input int L, input bit poke);
    logic [AW-1:0] a = AW'($urandom);
    logic [DW-1:0] wd = DW'($urandom);
    logic [DW-1:0] exp_wd = wide ? wd : (wd & 16'h00ff);
    logic [DW-1:0] last = '0;
    logic [DW-1:0] exp_rd;
    int m = (md == 3) ? 0 : md;
    int t1 = cyc(e_t1(m));
    int pw = cyc(e_pw(m, wide));
    int th = mx(cyc(e_dh(m)), cyc(e_ah(m)));
    int w_exp, busy_exp;
    int busy_n = 0, setup_n = 0, st_n = 0, post_n = 0, guard = 0;
    bit seen = 0, fin = 0, bad_addr = 0, bad_dir = 0, bad_wd = 0, got_err = 0;
    if (rmode == 1) w_exp = (L >= RDY) ? RDY : mx(pw, L + 1);
    else            w_exp = pw;
    busy_exp = mx(cyc(e_t0(m)), t1 + w_exp + th);

    @(negedge clk);
    req_i = 1'b1; req_write_i = wr; req_wide_i = wide; req_mode_i = 2'(md);
    req_addr_i = a; req_wdata_i = wd;
    @(negedge clk);
    req_i = 1'b0;
    while (!fin && guard < 2000) begin
      bit lo = wr ? !dev_wr_n_o : !dev_rd_n_o;
      bit other = wr ? !dev_rd_n_o : !dev_wr_n_o;
      guard++;
      if (other) bad_dir = 1;
      if (busy_o) begin
        busy_n++;
        if (dev_addr_o != a) bad_addr = 1;
        if (wr && dev_wdata_oe_o && dev_wdata_o != exp_wd) bad_wd = 1;
      end
      if (lo) begin
        int j = st_n;
        case (rmode)
          1: dev_ready_i = !(j < L);
          2: dev_ready_i = !(j >= WIN);
          default: dev_ready_i = 1'b1;
        endcase
        dev_rdata_i = DW'($urandom);
        last = dev_rdata_i;
        st_n++;
        seen = 1;
      end else begin
        dev_ready_i = 1'b1;
        dev_rdata_i = DW'($urandom);
        if (!seen && busy_o) setup_n++;
        if (seen && dev_wdata_oe_o) post_n++;
      end
      if (poke && busy_n == 3) begin
        req_i = 1'b1; req_addr_i = ~a; req_write_i = !wr; req_mode_i = 2'($urandom);
      end else begin
        req_i = 1'b0;
      end
      if (done_o) begin
        fin = 1;
        got_err = err_o;
      end else begin
        @(negedge clk);
      end
    end
    req_i = 1'b0;
    chk(fin, "R5 done", int'(fin), 1);
    chk(setup_n == t1, "R1 setup", setup_n, t1);
    chk(st_n == w_exp, rmode == 1 ? ((L >= RDY) ? "R10 width" : "R8 width")
                      : rmode == 2 ? "R9 width" : (wide ? "R2 width" : "R3 width"),
        st_n, w_exp);
    chk(busy_n == busy_exp, poke ? "R11 length" : "R5 busy", busy_n, busy_exp);
    chk(!bad_addr, poke ? "R11 addr" : "R7 addr", int'(bad_addr), 0);
    chk(!bad_dir, "R7 strobe dir", int'(bad_dir), 0);
    chk(got_err == (rmode == 1 && L >= RDY), "R10 err", int'(got_err),
        int'(rmode == 1 && L >= RDY));
    if (wr) begin
      chk(post_n == th, "R4 hold", post_n, th);
      chk(!bad_wd, wide ? "R7 wdata" : "R3 wdata", int'(bad_wd), 0);
    end else begin
      exp_rd = wide ? last : (last & 16'h00ff);
      chk(rdata_o == exp_rd, wide ? "R6 rdata" : "R3 rdata", int'(rdata_o), int'(exp_rd));
      repeat (3) begin
        @(negedge clk);
        dev_rdata_i = DW'($urandom);
      end
      chk(rdata_o == exp_rd, "R6 hold", int'(rdata_o), int'(exp_rd));
    end
  endtask

  initial begin
    void'($urandom(32'h1d5e_0c42));
    rst_n = 1'b0;
    req_i = 1'b0; req_write_i = 1'b0; req_wide_i = 1'b0; req_mode_i = '0;
    req_addr_i = '0; req_wdata_i = '0; dev_rdata_i = '0; dev_ready_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o && !err_o && dev_rd_n_o && dev_wr_n_o && !dev_wdata_oe_o,
        "R12 reset", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && dev_rd_n_o && dev_wr_n_o, "R12 after reset", int'(busy_o), 0);

    run(0, 1, 0, 0, 0, 0);
    run(1, 0, 1, 0, 0, 0);
    run(1, 1, 2, 0, 0, 0);
    run(0, 0, 2, 0, 0, 0);
    run(0, 1, 3, 0, 0, 0);                 // R1 code 3 behaves as code 0
    run(0, 1, 2, 1, cyc(100) - 1, 0);      // R8 release as width expires
    run(0, 1, 2, 1, cyc(100), 0);          // R8 one cycle later
    run(1, 1, 1, 1, RDY - 1, 0);           // R10 one short of limit
    run(0, 1, 1, 1, RDY, 0);               // R10 timeout
    run(1, 0, 0, 2, 0, 0);                 // R9 late ready ignored
    run(1, 1, 2, 0, 0, 1);                 // R11 request while busy
    for (int i = 0; i < 30; i++) begin
      run(1'($urandom), 1'($urandom), int'($urandom_range(0, 3)),
          int'($urandom_range(0, 2)), int'($urandom_range(0, 40)), 1'($urandom));
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule